// File: doc/BRIEF.md
# Power-Fail Write-Protect Memory Controller

This block sits between a host bus and a 32K x 8 static memory array and keeps the array's contents safe while the main supply is lost. Two digital status inputs come from external comparators. One reports that the supply is below the power-fail threshold. The other reports that the supply is below the backup-cell voltage. While the supply is good, host reads and writes reach the array unchanged, in the same cycle. Once power-fail is seen, the block cuts the host off from the array and turns off the read-data output enable. An access that is already running may first finish, but only within a bounded number of cycles.

When the supply returns, protection stays in force for a fixed recovery interval so that the host can settle. Only then do accesses reach the array again. The block also drives a source-select output that picks the backup cell whenever the supply is below the cell voltage.

A one-shot isolation latch models the factory state of the backup cell. The cell cannot be selected until the first time a valid supply is seen. After that moment the latch stays clear for good.

Top module: `pfwp_ctrl`

## Requirements
- R1: While reset is held, and right after it, `wp_active` and `iso_set` are 1. `mem_ce`, `mem_we` and `host_rdata_oe` are 0, and `src_backup` is 0.
- R2: With protection off and no pending failure, `mem_ce` equals `host_ce` in the same cycle. `mem_we` equals `host_ce & host_we`. Address and write data pass through unchanged. A read (`host_ce=1`, `host_we=0`) raises `host_rdata_oe` and presents `mem_rdata` on `host_rdata` in that cycle.
- R3: If a clock edge samples `pwr_fail=1` while `host_ce=0` and protection is off, `wp_active` is 1 from that edge on. While `wp_active` is 1, `mem_ce`, `mem_we` and `host_rdata_oe` stay 0 and `host_rdata` reads 0. Writes attempted during this time leave the array unchanged.
- R4: If that edge samples `host_ce=1`, the access continues to pass through. The first later edge that samples `host_ce=0` ends it and turns protection on.
- R5: If `host_ce` stays 1, protection is forced after exactly `TWPT_CYC` cycles of pass-through following the detecting edge.
- R6: An edge that samples `pwr_fail=0` during protection starts recovery. `wp_active` stays 1 for exactly `TCER_CYC` more cycles and then falls.
- R7: `pwr_fail=1` sampled during recovery keeps protection on. The next recovery again lasts the full `TCER_CYC` cycles, counted from its own start.
- R8: `iso_set` clears at the first edge after reset that samples `pwr_fail=0`. It never sets again until the next reset.
- R9: With `iso_set=0`, `src_backup` follows `below_cell` in the same cycle, in both directions.
- R10: While `iso_set=1`, `src_backup` is 0 whatever `below_cell` is.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Free-running clock |
| rst_n | input | 1 | Active-low reset; restores the factory isolation state |
| pwr_fail | input | 1 | Supply below power-fail threshold (comparator) |
| below_cell | input | 1 | Supply below backup-cell voltage (comparator) |
| host_ce | input | 1 | Host chip enable, active high |
| host_we | input | 1 | Host write enable, active high |
| host_addr | input | ADDR_W (15) | Host word address |
| host_wdata | input | DATA_W (8) | Host write data |
| host_rdata | output | DATA_W (8) | Read data to host, 0 when not driven |
| host_rdata_oe | output | 1 | Output enable for the read-data pads; 0 means high impedance |
| mem_ce | output | 1 | Gated chip enable to the array |
| mem_we | output | 1 | Gated write enable to the array |
| mem_addr | output | ADDR_W (15) | Address to the array |
| mem_wdata | output | DATA_W (8) | Write data to the array |
| mem_rdata | input | DATA_W (8) | Read data from the array |
| src_backup | output | 1 | 1 selects the backup cell, 0 the main supply |
| wp_active | output | 1 | Write protection in force |
| iso_set | output | 1 | Backup cell still isolated |

## Verification
A state machine stuck in the drain state shows up as `mem_ce` still following `host_ce` past `TWPT_CYC` cycles. The write that leaks through is then visible when the address is read back after recovery. A recovery counter that is off by one moves the fall of `wp_active` by one cycle, and the first check after the expected end of recovery catches that. A false exit from protection shows up either as an array word changed by a blocked write or as a premature `host_rdata_oe`. An isolation latch that never clears, or that clears too early, shows up on `src_backup` in the first cycle that `below_cell` is high.

// File: rtl/pfwp_pkg.sv
package pfwp_pkg;

  typedef enum logic [1:0] {
    ST_NORMAL  = 2'd0,
    ST_DRAIN   = 2'd1,
    ST_PROTECT = 2'd2,
    ST_RECOVER = 2'd3
  } pfwp_state_e;

  // A window of `limit` cycles has run out once the count of elapsed
  // cycles (cnt, starting at 0) reaches its last slot.
  function automatic logic count_expired(input int unsigned cnt,
                                         input int unsigned limit);
    return (cnt + 1) >= limit;
  endfunction

  function automatic int unsigned larger_of(input int unsigned a,
                                            input int unsigned b);
    return (a > b) ? a : b;
  endfunction

endpackage

// File: rtl/pfwp_fsm.sv
module pfwp_fsm
  import pfwp_pkg::*;
#(
  parameter int unsigned TWPT_CYC = 16,
  parameter int unsigned TCER_CYC = 6000000,
  parameter int unsigned CNT_W    = 23
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        pwr_fail,
  input  logic        host_ce,
  output pfwp_state_e state,
  output logic        drain_expire,
  output logic        recover_done
);

  pfwp_state_e      state_n;
  logic [CNT_W-1:0] cnt, cnt_n;

  assign drain_expire = (state == ST_DRAIN) && host_ce &&
                        count_expired(32'(cnt), TWPT_CYC);
  assign recover_done = (state == ST_RECOVER) && !pwr_fail &&
                        count_expired(32'(cnt), TCER_CYC);

  always_comb begin
    state_n = state;
    cnt_n   = cnt;
    unique case (state)
      ST_NORMAL: begin
        if (pwr_fail) begin
          state_n = host_ce ? ST_DRAIN : ST_PROTECT;
          cnt_n   = '0;
        end
      end
      ST_DRAIN: begin
        if (!host_ce || drain_expire) begin
          state_n = ST_PROTECT;
          cnt_n   = '0;
        end else begin
          cnt_n = cnt + CNT_W'(1);
        end
      end
      ST_PROTECT: begin
        if (!pwr_fail) begin
          state_n = ST_RECOVER;
          cnt_n   = '0;
        end
      end
      ST_RECOVER: begin
        if (pwr_fail) begin
          state_n = ST_PROTECT;
          cnt_n   = '0;
        end else if (recover_done) begin
          state_n = ST_NORMAL;
          cnt_n   = '0;
        end else begin
          cnt_n = cnt + CNT_W'(1);
        end
      end
      default: begin
        state_n = ST_PROTECT;
        cnt_n   = '0;
      end
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state <= ST_PROTECT;
      cnt   <= '0;
    end else begin
      state <= state_n;
      cnt   <= cnt_n;
    end
  end

endmodule

// File: rtl/pfwp_bus_gate.sv
module pfwp_bus_gate
  import pfwp_pkg::*;
#(
  parameter int unsigned ADDR_W = 15,
  parameter int unsigned DATA_W = 8
) (
  input  pfwp_state_e       state,
  input  logic              host_ce,
  input  logic              host_we,
  input  logic [ADDR_W-1:0] host_addr,
  input  logic [DATA_W-1:0] host_wdata,
  input  logic [DATA_W-1:0] mem_rdata,
  output logic              mem_ce,
  output logic              mem_we,
  output logic [ADDR_W-1:0] mem_addr,
  output logic [DATA_W-1:0] mem_wdata,
  output logic [DATA_W-1:0] host_rdata,
  output logic              host_rdata_oe,
  output logic              access_open
);

  assign access_open = (state == ST_NORMAL) || (state == ST_DRAIN);

  always_comb begin
    mem_ce        = access_open && host_ce;
    mem_we        = access_open && host_ce && host_we;
    mem_addr      = access_open ? host_addr  : '0;
    mem_wdata     = access_open ? host_wdata : '0;
    host_rdata_oe = access_open && host_ce && !host_we;
    host_rdata    = host_rdata_oe ? mem_rdata : '0;
  end

endmodule

// File: rtl/pfwp_src_sel.sv
module pfwp_src_sel (
  input  logic clk,
  input  logic rst_n,
  input  logic pwr_fail,
  input  logic below_cell,
  output logic iso_set,
  output logic src_backup
);

  logic iso_q;

  // One-shot: reset is the factory state; the first sampled valid supply
  // releases the cell and nothing sets it again.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)
      iso_q <= 1'b1;
    else if (!pwr_fail)
      iso_q <= 1'b0;
  end

  assign iso_set    = iso_q;
  assign src_backup = below_cell && !iso_q;

endmodule

// File: rtl/pfwp_ctrl.sv
module pfwp_ctrl
  import pfwp_pkg::*;
#(
  parameter int unsigned ADDR_W   = 15,
  parameter int unsigned DATA_W   = 8,
  parameter int unsigned TWPT_CYC = 16,
  parameter int unsigned TCER_CYC = 6000000
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              pwr_fail,
  input  logic              below_cell,
  input  logic              host_ce,
  input  logic              host_we,
  input  logic [ADDR_W-1:0] host_addr,
  input  logic [DATA_W-1:0] host_wdata,
  output logic [DATA_W-1:0] host_rdata,
  output logic              host_rdata_oe,
  output logic              mem_ce,
  output logic              mem_we,
  output logic [ADDR_W-1:0] mem_addr,
  output logic [DATA_W-1:0] mem_wdata,
  input  logic [DATA_W-1:0] mem_rdata,
  output logic              src_backup,
  output logic              wp_active,
  output logic              iso_set
);

  localparam int unsigned CNT_MAX = larger_of(TWPT_CYC, TCER_CYC);
  localparam int unsigned CNT_W   = $clog2(CNT_MAX + 1);

  pfwp_state_e st;
  logic        drain_expire;
  logic        recover_done;
  logic        access_open;
  logic        in_drain;
  logic        in_recover;

  pfwp_fsm #(
    .TWPT_CYC(TWPT_CYC),
    .TCER_CYC(TCER_CYC),
    .CNT_W   (CNT_W)
  ) u_fsm (
    .clk         (clk),
    .rst_n       (rst_n),
    .pwr_fail    (pwr_fail),
    .host_ce     (host_ce),
    .state       (st),
    .drain_expire(drain_expire),
    .recover_done(recover_done)
  );

  pfwp_bus_gate #(
    .ADDR_W(ADDR_W),
    .DATA_W(DATA_W)
  ) u_gate (
    .state        (st),
    .host_ce      (host_ce),
    .host_we      (host_we),
    .host_addr    (host_addr),
    .host_wdata   (host_wdata),
    .mem_rdata    (mem_rdata),
    .mem_ce       (mem_ce),
    .mem_we       (mem_we),
    .mem_addr     (mem_addr),
    .mem_wdata    (mem_wdata),
    .host_rdata   (host_rdata),
    .host_rdata_oe(host_rdata_oe),
    .access_open  (access_open)
  );

  pfwp_src_sel u_src (
    .clk       (clk),
    .rst_n     (rst_n),
    .pwr_fail  (pwr_fail),
    .below_cell(below_cell),
    .iso_set   (iso_set),
    .src_backup(src_backup)
  );

  assign in_drain   = (st == ST_DRAIN);
  assign in_recover = (st == ST_RECOVER);
  assign wp_active  = !access_open;

endmodule

// File: rtl/pfwp_ctrl_chk.sv
module pfwp_ctrl_chk #(
  parameter int unsigned TWPT_CYC = 16,
  parameter int unsigned TCER_CYC = 6000000
) (
  input logic clk,
  input logic rst_n,
  input logic pwr_fail,
  input logic below_cell,
  input logic host_ce,
  input logic mem_ce,
  input logic mem_we,
  input logic host_rdata_oe,
  input logic wp_active,
  input logic iso_set,
  input logic src_backup,
  input logic in_drain,
  input logic in_recover,
  input logic drain_expire,
  input logic recover_done
);

  logic [31:0] drn_run;
  logic [31:0] rec_run;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      drn_run <= '0;
      rec_run <= '0;
    end else begin
      drn_run <= in_drain   ? drn_run + 32'd1 : 32'd0;
      rec_run <= in_recover ? rec_run + 32'd1 : 32'd0;
    end
  end

  assert_gate_closed_R3: assert property (@(posedge clk) disable iff (!rst_n)
    wp_active |-> (!mem_ce && !mem_we && !host_rdata_oe));

  assert_enter_protect_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (!wp_active && !in_drain && pwr_fail && !host_ce) |=> wp_active);

  assert_drain_pass_R4: assert property (@(posedge clk) disable iff (!rst_n)
    in_drain |-> (mem_ce == host_ce));

  assert_drain_bound_R5: assert property (@(posedge clk) disable iff (!rst_n)
    in_drain |-> (drn_run < TWPT_CYC));

  assert_drain_expire_R5: assert property (@(posedge clk) disable iff (!rst_n)
    drain_expire |=> wp_active);

  assert_recover_bound_R6: assert property (@(posedge clk) disable iff (!rst_n)
    in_recover |-> (rec_run < TCER_CYC));

  assert_recover_len_R6: assert property (@(posedge clk) disable iff (!rst_n)
    ($fell(in_recover) && !wp_active) |-> ($past(rec_run) == TCER_CYC - 1));

  assert_recover_done_R6: assert property (@(posedge clk) disable iff (!rst_n)
    recover_done |=> !wp_active);

  assert_fail_in_recover_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (in_recover && pwr_fail) |=> (wp_active && !in_recover));

  assert_iso_sticky_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !iso_set |=> !iso_set);

  assert_iso_release_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (iso_set && !pwr_fail) |=> !iso_set);

  assert_src_follow_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (!iso_set && $rose(below_cell)) |-> src_backup);

  assert_iso_blocks_R10: assert property (@(posedge clk) disable iff (!rst_n)
    iso_set |-> !src_backup);

endmodule

bind pfwp_ctrl pfwp_ctrl_chk #(
  .TWPT_CYC(TWPT_CYC),
  .TCER_CYC(TCER_CYC)
) u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .pwr_fail     (pwr_fail),
  .below_cell   (below_cell),
  .host_ce      (host_ce),
  .mem_ce       (mem_ce),
  .mem_we       (mem_we),
  .host_rdata_oe(host_rdata_oe),
  .wp_active    (wp_active),
  .iso_set      (iso_set),
  .src_backup   (src_backup),
  .in_drain     (in_drain),
  .in_recover   (in_recover),
  .drain_expire (drain_expire),
  .recover_done (recover_done)
);

// File: tb/pfwp_ctrl_tb.sv
`timescale 1ns/1ps
module pfwp_ctrl_tb;

  localparam int AW   = 6;
  localparam int DW   = 8;
  localparam int TWPT = 5;
  localparam int TCER = 20;
  localparam int NW   = 1 << AW;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          pwr_fail = 1'b1;
  logic          below_cell = 1'b1;
  logic          host_ce = 1'b0;
  logic          host_we = 1'b0;
  logic [AW-1:0] host_addr = '0;
  logic [DW-1:0] host_wdata = '0;
  logic [DW-1:0] host_rdata;
  logic          host_rdata_oe;
  logic          mem_ce, mem_we;
  logic [AW-1:0] mem_addr;
  logic [DW-1:0] mem_wdata;
  logic [DW-1:0] mem_rdata;
  logic          src_backup, wp_active, iso_set;

  int n_chk  = 0;
  int n_fail = 0;

  always #10 clk = ~clk;

  // behavioural array
  logic [DW-1:0] arr [NW];
  initial for (int i = 0; i < NW; i++) arr[i] = '0;
  always @(posedge clk) if (mem_ce && mem_we) arr[mem_addr] <= mem_wdata;
  assign mem_rdata = arr[mem_addr];

  pfwp_ctrl #(.ADDR_W(AW), .DATA_W(DW), .TWPT_CYC(TWPT), .TCER_CYC(TCER)) u_dut (
    .clk(clk), .rst_n(rst_n), .pwr_fail(pwr_fail), .below_cell(below_cell),
    .host_ce(host_ce), .host_we(host_we), .host_addr(host_addr),
    .host_wdata(host_wdata), .host_rdata(host_rdata),
    .host_rdata_oe(host_rdata_oe), .mem_ce(mem_ce), .mem_we(mem_we),
    .mem_addr(mem_addr), .mem_wdata(mem_wdata), .mem_rdata(mem_rdata),
    .src_backup(src_backup), .wp_active(wp_active), .iso_set(iso_set)
  );

  function automatic logic [DW-1:0] pat(input int a);
    return DW'((a * 37 + 5) % 256);
  endfunction

  task automatic chk(input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic summary();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
  endtask

  task automatic idle_bus();
    host_ce = 1'b0; host_we = 1'b0;
  endtask

  task automatic do_write(input int a, input logic [DW-1:0] d);
    @(negedge clk);
    host_ce = 1'b1; host_we = 1'b1; host_addr = AW'(a); host_wdata = d;
    #1;
    chk("R2", "mem_we", 32'(mem_we), 32'(1));
    chk("R2", "mem_addr", 32'(mem_addr), 32'(a));
    @(negedge clk);
    idle_bus();
  endtask

  task automatic do_read(input string req, input int a, input logic [DW-1:0] exp);
    @(negedge clk);
    host_ce = 1'b1; host_we = 1'b0; host_addr = AW'(a);
    #1;
    chk(req, "rdata_oe", 32'(host_rdata_oe), 32'(1));
    chk(req, "rdata", 32'(host_rdata), 32'(exp));
    @(negedge clk);
    idle_bus();
  endtask

  // Caller has just driven pwr_fail=0 at a falling edge.
  task automatic recover_watch(input string req);
    for (int m = 1; m <= TCER + 2; m++) begin
      @(negedge clk); #1;
      chk(req, "wp_active during recovery", 32'(wp_active), 32'(m <= TCER));
      chk("R8", "iso stays clear", 32'(iso_set), 32'(0));
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog expired");
    summary();
    $finish;
  end

  initial begin
    // R1 reset state
    repeat (3) @(posedge clk);
    @(negedge clk); #1;
    chk("R1", "wp_active", 32'(wp_active), 32'(1));
    chk("R1", "iso_set", 32'(iso_set), 32'(1));
    chk("R1", "mem_ce", 32'(mem_ce), 32'(0));
    chk("R1", "rdata_oe", 32'(host_rdata_oe), 32'(0));
    chk("R1", "src_backup", 32'(src_backup), 32'(0));
    rst_n = 1'b1;
    repeat (2) @(negedge clk); #1;
    chk("R10", "src while isolated", 32'(src_backup), 32'(0));
    chk("R8", "iso held while supply bad", 32'(iso_set), 32'(1));

    // first valid supply: isolation clears, recovery runs
    pwr_fail = 1'b0;
    recover_watch("R6");
    below_cell = 1'b1; #1;
    chk("R9", "src follows rise", 32'(src_backup), 32'(1));
    below_cell = 1'b0; #1;
    chk("R9", "src follows fall", 32'(src_backup), 32'(0));

    // R2 full sweep
    for (int a = 0; a < NW; a++) do_write(a, pat(a));
    for (int a = 0; a < NW; a++) do_read("R2", a, pat(a));

    // R3: failure with idle bus, blocked accesses
    @(negedge clk); pwr_fail = 1'b1;
    @(negedge clk); #1;
    chk("R3", "wp_active after idle failure", 32'(wp_active), 32'(1));
    for (int a = 0; a < NW; a++) begin
      @(negedge clk);
      host_ce = 1'b1; host_we = a[0]; host_addr = AW'(a); host_wdata = ~pat(a);
      #1;
      chk("R3", "mem_ce blocked", 32'(mem_ce), 32'(0));
      chk("R3", "rdata_oe off", 32'(host_rdata_oe), 32'(0));
      chk("R3", "rdata zero", 32'(host_rdata), 32'(0));
    end
    @(negedge clk); idle_bus(); pwr_fail = 1'b0;
    recover_watch("R6");
    for (int a = 0; a < NW; a++) do_read("R3", a, pat(a));

    // R4/R5: access held for h cycles when failure arrives
    for (int h = 0; h <= TWPT + 2; h++) begin
      int lim;
      lim = (h < TWPT) ? h : TWPT;
      @(negedge clk);
      pwr_fail = 1'b1;
      host_ce = (h > 0); host_we = 1'b1;
      host_addr = AW'(10 + h); host_wdata = DW'(8'hA0 + h);
      for (int j = 1; j <= TWPT + 3; j++) begin
        @(negedge clk);
        host_ce = (j < h);
        #1;
        chk((h > TWPT) ? "R5" : "R4", "wp_active in drain sweep",
            32'(wp_active), 32'(j > lim));
        chk((h > TWPT) ? "R5" : "R4", "mem_ce in drain sweep",
            32'(mem_ce), 32'((j <= lim) && (j < h)));
      end
      @(negedge clk); idle_bus(); pwr_fail = 1'b0;
      recover_watch("R6");
      do_read("R4", 10 + h, (h > 0) ? DW'(8'hA0 + h) : pat(10 + h));
    end

    // R7: failure during recovery restarts it
    @(negedge clk); pwr_fail = 1'b1;
    repeat (2) @(negedge clk);
    pwr_fail = 1'b0;
    repeat (5) begin
      @(negedge clk); #1;
      chk("R7", "wp in partial recovery", 32'(wp_active), 32'(1));
    end
    pwr_fail = 1'b1;
    repeat (3) begin
      @(negedge clk); #1;
      chk("R7", "wp after refail", 32'(wp_active), 32'(1));
    end
    pwr_fail = 1'b0;
    recover_watch("R7");

    // R8/R9 on a later power-down: cell now selectable
    @(negedge clk); pwr_fail = 1'b1; below_cell = 1'b1;
    @(negedge clk); #1;
    chk("R8", "iso stays clear on later failure", 32'(iso_set), 32'(0));
    chk("R9", "backup selected", 32'(src_backup), 32'(1));
    below_cell = 1'b0; #1;
    chk("R9", "main selected", 32'(src_backup), 32'(0));

    summary();
    $finish;
  end

endmodule